// File: doc/BRIEF.md
# Double-Buffered Linear Framebuffer Scanout

This block turns the current beam position of a fixed 320x240 indexed-colour display into video RAM read requests and, a fixed number of cycles later, a palette index per pixel. The video RAM holds 128KB and is split into two 64KB halves. One half is scanned out while the other belongs to the CPU. A CPU request exchanges the two roles, but only at the start of vertical blanking, so a frame is never torn between buffers.

Pixels are packed linearly with no padding, at either 8 bits per pixel (one byte each, 320-byte lines) or 4 bits per pixel (two per byte, 160-byte lines). A 5-bit count blanks the same number of lines at the top and at the bottom of the frame, for letterboxing and to shrink the storage a frame needs. The first line that is not blanked is read from offset 0 of the display buffer. Depth, blank count and buffer choice are all sampled together at the start of vertical blanking.

Top module: `fb_scanout`

## Requirements
- R1: After reset the display buffer is 0, no swap is pending, the depth is 4bpp, the blank count is 0, `rd_en` is 0 and `pix_idx` is 0.
- R2: At 8bpp a shown pixel at column x of shown line L (L = y minus the blank count) reads byte address `{disp_buf, L*320 + x}`, and its palette index is that whole byte.
- R3: At 4bpp a shown pixel reads byte address `{disp_buf, L*160 + x/2}`. An even x takes bits 7:4 of the byte and an odd x takes bits 3:0, and the index is zero-extended to 8 bits.
- R4: With blank count N, lines y < N and y >= 240 - N issue no read and give index 0. Line N is read from offset 0.
- R5: At 8bpp a shown line whose last byte would lie at offset 65536 or beyond issues no read and gives index 0. With no blanking, y = 203 is shown and y = 204 is blanked.
- R6: Beam positions with x >= 320 or y >= 240 issue no read and give index 0.
- R7: A `swap_req` pulse sets `swap_pending`, which stays 1 until the next start of vertical blanking (the cycle with y = 240 and x = 0). At that edge `disp_buf` inverts and `swap_pending` clears. `disp_buf` changes at no other time.
- R8: A `swap_req` in the same cycle as the start of vertical blanking inverts `disp_buf` at once and leaves `swap_pending` at 0.
- R9: Changes to `cfg_depth8` and `cfg_blank` take effect only at the next start of vertical blanking.
- R10: `rd_en`/`rd_addr` are registered one cycle after the beam position. `rd_data` is expected one cycle after that, and `pix_idx` is registered three cycles after the beam position.
- R11: Every read targets the display buffer: `rd_addr[16]` equals `disp_buf` whenever `rd_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_x | input | 10 | Beam column |
| pix_y | input | 10 | Beam line |
| cfg_depth8 | input | 1 | 1 selects 8bpp, 0 selects 4bpp |
| cfg_blank | input | 5 | Lines blanked at the top and at the bottom |
| swap_req | input | 1 | One-cycle request to exchange the buffers |
| rd_data | input | 8 | Byte returned by video RAM one cycle after a read |
| rd_en | output | 1 | Video RAM read strobe |
| rd_addr | output | 17 | Byte address; bit 16 picks the 64KB half |
| pix_idx | output | 8 | Palette index for the pixel |
| disp_buf | output | 1 | Half currently scanned out; the CPU owns the other |
| swap_pending | output | 1 | A swap is waiting for vertical blanking |

## Verification
A swap request can arrive in the very cycle that vertical blanking starts, where the request latch and the frame-boundary update both act on the same edge. The bench drives `swap_req` high with the beam at y = 240, x = 0. It expects `disp_buf` to invert on that edge and `swap_pending` to stay 0, and it confirms that the next frame's reads carry the new buffer bit. A request made away from the boundary is checked separately: it must stay pending and leave the buffer unchanged until the boundary arrives.

// File: rtl/fb_scanout.sv
module fb_scanout #(
  parameter int H_ACT = 320,
  parameter int V_ACT = 240,
  parameter int XW    = 10,
  parameter int YW    = 10,
  parameter int BW    = 5,
  parameter int AW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] pix_x,
  input  logic [YW-1:0] pix_y,
  input  logic          cfg_depth8,
  input  logic [BW-1:0] cfg_blank,
  input  logic          swap_req,
  input  logic [7:0]    rd_data,
  output logic          rd_en,
  output logic [AW:0]   rd_addr,
  output logic [7:0]    pix_idx,
  output logic          disp_buf,
  output logic          swap_pending
);
  localparam int OW = AW + 2;

  logic          depth_q;
  logic [BW-1:0] blank_q;
  logic          vbs;
  logic [YW-1:0] blank_y, line;
  logic [OW-1:0] stride, line_base, col, off;
  logic          in_area, in_band, fits, vis;
  logic          nib1, hi1, nib2, hi2, vis2;

  assign vbs     = (pix_y == YW'(V_ACT)) && (pix_x == '0);
  assign blank_y = YW'(blank_q);
  assign line    = pix_y - blank_y;
  assign stride  = depth_q ? OW'(H_ACT) : OW'(H_ACT / 2);
  assign line_base = OW'(line) * stride;
  assign col     = depth_q ? OW'(pix_x) : OW'(pix_x >> 1);
  assign off     = line_base + col;
  assign in_area = (pix_x < XW'(H_ACT)) && (pix_y < YW'(V_ACT));
  assign in_band = (pix_y >= blank_y) && (pix_y < YW'(V_ACT) - blank_y);
  assign fits    = (line_base + stride) <= (OW'(1) << AW);
  assign vis     = in_area && in_band && fits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth_q      <= 1'b0;
      blank_q      <= '0;
      disp_buf     <= 1'b0;
      swap_pending <= 1'b0;
    end else if (vbs) begin
      depth_q      <= cfg_depth8;
      blank_q      <= cfg_blank;
      disp_buf     <= disp_buf ^ (swap_pending | swap_req);
      swap_pending <= 1'b0;
    end else if (swap_req) begin
      swap_pending <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_en   <= 1'b0;
      rd_addr <= '0;
      nib1    <= 1'b0;
      hi1     <= 1'b0;
      vis2    <= 1'b0;
      nib2    <= 1'b0;
      hi2     <= 1'b0;
      pix_idx <= '0;
    end else begin
      rd_en   <= vis;
      rd_addr <= vis ? {disp_buf, off[AW-1:0]} : '0;
      nib1    <= !depth_q;
      hi1     <= !pix_x[0];
      vis2    <= rd_en;
      nib2    <= nib1;
      hi2     <= hi1;
      if (!vis2)
        pix_idx <= '0;
      else if (nib2)
        pix_idx <= {4'h0, hi2 ? rd_data[7:4] : rd_data[3:0]};
      else
        pix_idx <= rd_data;
    end
  end
endmodule

// File: rtl/fb_scanout_chk.sv
module fb_scanout_chk #(
  parameter int H_ACT = 320,
  parameter int V_ACT = 240,
  parameter int XW    = 10,
  parameter int YW    = 10,
  parameter int AW    = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [XW-1:0] pix_x,
  input logic [YW-1:0] pix_y,
  input logic          swap_req,
  input logic          rd_en,
  input logic [AW:0]   rd_addr,
  input logic [7:0]    pix_idx,
  input logic          disp_buf,
  input logic          swap_pending
);
  logic vbs;
  assign vbs = (pix_y == YW'(V_ACT)) && (pix_x == '0);

  assert_rd_in_area_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> ($past(pix_x) < XW'(H_ACT) && $past(pix_y) < YW'(V_ACT)));

  assert_rd_buf_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> rd_addr[AW] == disp_buf);

  assert_buf_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(disp_buf) |-> $past(vbs));

  assert_pend_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_req && !vbs) |=> swap_pending);

  assert_coincide_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_req && vbs) |=> (!swap_pending && disp_buf != $past(disp_buf)));

  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en, 2) |-> pix_idx == 8'h00);
endmodule

bind fb_scanout fb_scanout_chk #(
  .H_ACT(H_ACT), .V_ACT(V_ACT), .XW(XW), .YW(YW), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y),
  .swap_req(swap_req), .rd_en(rd_en), .rd_addr(rd_addr),
  .pix_idx(pix_idx), .disp_buf(disp_buf), .swap_pending(swap_pending)
);

// File: tb/test_fb_scanout.sv
module test_fb_scanout;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  pix_x = '0;
  logic [9:0]  pix_y = 10'd300;
  logic        cfg_depth8 = 1'b0;
  logic [4:0]  cfg_blank = '0;
  logic        swap_req = 1'b0;
  logic [7:0]  rd_data = '0;
  logic        rd_en;
  logic [16:0] rd_addr;
  logic [7:0]  pix_idx;
  logic        disp_buf, swap_pending;

  int checks = 0, errors = 0;
  bit done = 0;
  logic       m_depth = 0, m_buf = 0, m_pend = 0;
  int         m_blank = 0;

  always #4 clk = ~clk;

  fb_scanout i_fb_scanout (
    .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y),
    .cfg_depth8(cfg_depth8), .cfg_blank(cfg_blank), .swap_req(swap_req),
    .rd_data(rd_data), .rd_en(rd_en), .rd_addr(rd_addr), .pix_idx(pix_idx),
    .disp_buf(disp_buf), .swap_pending(swap_pending)
  );

  function automatic logic [7:0] ram_byte(logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ {a[16], 7'h2A};
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= ram_byte(rd_addr);

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic probe(string req, int x, int y);
    int line = y - m_blank;
    int stride = m_depth ? 320 : 160;
    bit vis = x < 320 && y < 240 && y >= m_blank && y < 240 - m_blank
              && (line * stride + stride) <= 65536;
    int off = line * stride + (m_depth ? x : x / 2);
    logic [16:0] addr = {m_buf, 16'(off)};
    logic [7:0] b = ram_byte(addr);
    int exp_idx = !vis ? 0 : m_depth ? int'(b) : ((x % 2 == 0) ? int'(b[7:4]) : int'(b[3:0]));
    pix_x = 10'(x); pix_y = 10'(y);
    @(negedge clk);
    chk(req, "rd_en", int'(rd_en), int'(vis));
    if (vis) chk(req, "rd_addr", int'(rd_addr), int'(addr));
    pix_x = 10'd400;
    @(negedge clk);
    @(negedge clk);
    chk(req, $sformatf("pix_idx(%0d,%0d)", x, y), int'(pix_idx), exp_idx);
  endtask

  task automatic frame_boundary();
    pix_x = 0; pix_y = 10'd240;
    @(negedge clk);
    pix_y = 10'd241;
    m_depth = cfg_depth8; m_blank = int'(cfg_blank);
    if (m_pend) m_buf = ~m_buf;
    m_pend = 0;
  endtask

  task automatic t_reset();
    chk("R1", "disp_buf", int'(disp_buf), 0);
    chk("R1", "swap_pending", int'(swap_pending), 0);
    chk("R1", "rd_en", int'(rd_en), 0);
    chk("R1", "pix_idx", int'(pix_idx), 0);
    probe("R1", 1, 0);
  endtask

  task automatic t_4bpp();
    probe("R3", 0, 0);
    probe("R3", 1, 0);
    probe("R3", 5, 7);
    probe("R3", 319, 239);
    probe("R6", 320, 10);
    probe("R6", 10, 240);
  endtask

  task automatic t_8bpp();
    cfg_depth8 = 1;
    probe("R9", 7, 3);
    frame_boundary();
    probe("R2", 0, 0);
    probe("R2", 319, 100);
    probe("R5", 17, 203);
    probe("R5", 5, 204);
    probe("R10", 2, 2);
  endtask

  task automatic t_blank();
    cfg_blank = 5'd31;
    probe("R9", 3, 10);
    frame_boundary();
    probe("R4", 3, 30);
    probe("R4", 3, 31);
    probe("R4", 3, 208);
    probe("R4", 3, 209);
    cfg_depth8 = 0; cfg_blank = 5'd10;
    frame_boundary();
    probe("R4", 8, 9);
    probe("R4", 9, 10);
    probe("R4", 9, 229);
    probe("R4", 9, 230);
  endtask

  task automatic t_swap();
    swap_req = 1;
    @(negedge clk);
    swap_req = 0; m_pend = 1;
    chk("R7", "swap_pending set", int'(swap_pending), 1);
    chk("R7", "disp_buf held", int'(disp_buf), 0);
    probe("R11", 4, 20);
    chk("R7", "still pending", int'(swap_pending), 1);
    frame_boundary();
    chk("R7", "disp_buf swapped", int'(disp_buf), 1);
    chk("R7", "pending cleared", int'(swap_pending), 0);
    probe("R11", 4, 20);
  endtask

  task automatic t_coincide();
    pix_x = 0; pix_y = 10'd240; swap_req = 1;
    @(negedge clk);
    swap_req = 0; pix_y = 10'd241; m_buf = ~m_buf;
    chk("R8", "disp_buf", int'(disp_buf), int'(m_buf));
    chk("R8", "swap_pending", int'(swap_pending), 0);
    probe("R8", 6, 50);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_4bpp();
    t_8bpp();
    t_blank();
    t_swap();
    t_coincide();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule